// File: doc/BRIEF.md
# Bit-Serial Ternary Search Engine

This block holds a table of ternary entries and tells which of them agree with a search key. Each entry has a value and a care mask, so any bit of an entry can be marked don't-care. Instead of comparing whole words at once, the engine walks the key one bit position per clock. It starts at the top bit and moves down toward bit zero.

Every entry carries an active flag. A search sets the flag of every written entry. An entry clears its flag at its first disagreeing bit and ignores all later bits. This is the digital stand-in for cutting power to a row that has already lost. Because a disagreement near the top of the key removes most rows early, the number of rows still taking part falls quickly. That number is reported every cycle.

The search stops after the last bit. It also stops at once when no row is left active. At the end, a one-cycle strobe marks the result. The result is the final set of active rows, plus the lowest-numbered row in that set and a flag that says the set is not empty. Writes share the table with searches, so a write cannot land while a search is running.

Top module: `bstcam_top`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `hit`, `match_vec` and `active_cnt` are all zero, and no entry counts as written.
- R2: When `wr_en` and `wr_ready` are both high at a clock edge, the entry at `wr_addr` takes `wr_data` and `wr_care` and becomes written. A care bit of 1 means the bit is compared; a care bit of 0 means the bit is don't-care.
- R3: An entry matches a key when every bit whose care bit is 1 equals the key bit at the same position. Don't-care bits match either key value.
- R4: The edge that accepts `srch_start` is edge 0. Edge k (k ≥ 1) examines key bit WORD_W-k, so bit WORD_W-1 goes first and bit 0 goes last.
- R5: An entry that has never been written is never active and never matches.
- R6: In the first busy cycle, `active_cnt` equals the number of written entries. From then on, `active_cnt` always equals the number of active rows and never rises during a search.
- R7: If some row survives to bit 0, `done` is high for exactly one cycle, right after edge WORD_W. `busy` is low in that same cycle.
- R8: If no row is left active after edge j (j < WORD_W), the search ends and `done` is high right after edge j. When no entry is written, j is 1.
- R9: While `done` is high, `match_vec` holds the rows that matched. `hit` is the OR of `match_vec`, and `hit_idx` is the lowest set index (0 when `hit` is 0). These values stay unchanged until the next search starts.
- R10: `wr_ready` is low while `busy` is high and while `srch_start` is high. A `wr_en` given while `wr_ready` is low changes no entry.
- R11: A `srch_start` given while `busy` is high is ignored. The running search ends with its own result, and no second search follows it.
- R12: A new search may be started in the cycle in which `done` is high. It is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| wr_en | input | 1 | Write request |
| wr_addr | input | $clog2(NUM_WORDS) | Entry to write |
| wr_data | input | WORD_W | Entry value |
| wr_care | input | WORD_W | Care mask: 1 = compare, 0 = don't-care |
| wr_ready | output | 1 | A write is taken at this edge |
| srch_start | input | 1 | Start a search, accepted only when idle |
| srch_key | input | WORD_W | Search key, sampled on the accepting edge |
| busy | output | 1 | A search is running |
| done | output | 1 | One-cycle strobe: the result is valid |
| match_vec | output | NUM_WORDS | Active flags of all rows; after done, the matching rows |
| hit | output | 1 | At least one row matched |
| hit_idx | output | $clog2(NUM_WORDS) | Lowest matching row |
| active_cnt | output | $clog2(NUM_WORDS+1) | Number of rows active in this cycle |

## Verification
Searches are run against several tables:
- An empty table shows that unwritten rows stay out (R5) and that the shortest finish is one cycle (R8).
- A key that loses every row at its top bit, and another that loses the last row a few bits down, check that the finish cycle follows the last row to drop out, not the key width.
- Keys that hit an exact entry, a partly don't-care entry, an entry that cares only about its top bit, and an all-don't-care entry check ternary matching and lowest-index priority when several rows agree.
- A write held during a search, a second start pulse during a search, and a start in the done cycle check the write stall, the ignored start and back-to-back searches.
- A final set of random keys, each derived from a stored entry with a single flipped bit, exercises drop-out at many depths.

// File: rtl/bstcam_pkg.sv
package bstcam_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/bstcam_row.sv
module bstcam_row #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  wr_care,
  input  logic          load,
  input  logic          step,
  input  logic [IW-1:0] bit_idx,
  input  logic          key_bit,
  output logic          active_o,
  output logic          act_nxt_o
);
  logic [W-1:0] data_q, care_q;
  logic         valid_q, active_q, active_d, bit_ok;

  // entry storage: data path, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_sel) begin
      data_q <= wr_data;
      care_q <= wr_care;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= 1'b0;
    else if (wr_sel) valid_q <= 1'b1;
  end

  // one ternary cell compare at the current bit position
  assign bit_ok    = ~care_q[bit_idx] | (data_q[bit_idx] == key_bit);
  assign act_nxt_o = active_q & bit_ok;

  always_comb begin
    active_d = active_q;
    if (load)      active_d = valid_q;
    else if (step) active_d = act_nxt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  assign active_o = active_q;

  // R5: an unwritten row never takes part
  a_r5_invalid_row_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> !active_q);

  // R3: a compared bit that disagrees drops the row on the next edge
  a_r3_drop_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && active_q && care_q[bit_idx] && (data_q[bit_idx] != key_bit)) |=> !active_q);
endmodule

// File: rtl/bstcam_popcnt.sv
module bstcam_popcnt #(
  parameter int N  = 128,
  parameter int CW = $clog2(N+1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/bstcam_prienc.sv
module bstcam_prienc #(
  parameter int N  = 128,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [AW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (vec[i]) idx = AW'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/bstcam_top.sv
module bstcam_top #(
  parameter int NUM_WORDS = 128,
  parameter int WORD_W    = 64,
  localparam int AW = $clog2(NUM_WORDS),
  localparam int IW = $clog2(WORD_W),
  localparam int CW = $clog2(NUM_WORDS+1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [WORD_W-1:0]    wr_care,
  output logic                 wr_ready,
  input  logic                 srch_start,
  input  logic [WORD_W-1:0]    srch_key,
  output logic                 busy,
  output logic                 done,
  output logic [NUM_WORDS-1:0] match_vec,
  output logic                 hit,
  output logic [AW-1:0]        hit_idx,
  output logic [CW-1:0]        active_cnt
);
  import bstcam_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  scan_state_e          state_q, state_d;
  logic [IW-1:0]        bit_q, bit_d;
  logic [WORD_W-1:0]    key_q, key_d;
  logic                 done_q, done_d;
  logic                 start_acc, step, finish, wr_fire, key_en;
  logic [NUM_WORDS-1:0] act_vec, act_nxt;

  assign step      = (state_q == ST_SCAN);
  assign start_acc = srch_start && (state_q == ST_IDLE);
  assign wr_ready  = (state_q == ST_IDLE) && !srch_start;
  assign wr_fire   = wr_en && wr_ready;
  assign finish    = step && ((bit_q == '0) || !(|act_nxt));
  assign key_en    = start_acc || step;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    key_d   = key_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_acc) begin
          state_d = ST_SCAN;
          bit_d   = IW'(WORD_W-1);
          key_d   = srch_key;
        end
      end
      ST_SCAN: begin
        key_d = key_q << 1;
        bit_d = bit_q - 1'b1;
        if (finish) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (key_en) key_q <= key_d;
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_row
    bstcam_row #(.W(WORD_W), .IW(IW)) row_i (
      .clk      (clk),
      .rst_n    (rst_s),
      .wr_sel   (wr_fire && (wr_addr == AW'(g))),
      .wr_data  (wr_data),
      .wr_care  (wr_care),
      .load     (start_acc),
      .step     (step),
      .bit_idx  (bit_q),
      .key_bit  (key_q[WORD_W-1]),
      .active_o (act_vec[g]),
      .act_nxt_o(act_nxt[g])
    );
  end

  bstcam_popcnt #(.N(NUM_WORDS), .CW(CW)) cnt_i (.vec(act_vec), .cnt(active_cnt));
  bstcam_prienc #(.N(NUM_WORDS), .AW(AW)) enc_i (.vec(act_vec), .found(hit), .idx(hit_idx));

  assign busy      = step;
  assign done      = done_q;
  assign match_vec = act_vec;

  a_r6_cnt_no_rise: assert property (@(posedge clk) disable iff (!rst_s)
    busy |=> (active_cnt <= $past(active_cnt)));
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  a_r4_last_bit_ends: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && (bit_q == '0)) |=> (!busy && done));
  a_r10_no_write_in_scan: assert property (@(posedge clk) disable iff (!rst_s)
    busy |-> !wr_ready);
  a_r9_idx_points_at_match: assert property (@(posedge clk) disable iff (!rst_s)
    hit |-> match_vec[hit_idx]);
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && srch_start && !finish) |=> busy);
endmodule

// File: tb/bstcam_top_tb_top.sv
module bstcam_top_tb_top;
  localparam int N  = 128;
  localparam int W  = 64;
  localparam int AW = $clog2(N);
  localparam int CW = $clog2(N+1);

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_ready, srch_start, busy, done, hit;
  logic [AW-1:0] wr_addr, hit_idx;
  logic [W-1:0]  wr_data, wr_care, srch_key;
  logic [N-1:0]  match_vec;
  logic [CW-1:0] active_cnt;

  always #2.5 clk = ~clk;

  bstcam_top #(.NUM_WORDS(N), .WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_care(wr_care), .wr_ready(wr_ready),
    .srch_start(srch_start), .srch_key(srch_key), .busy(busy), .done(done),
    .match_vec(match_vec), .hit(hit), .hit_idx(hit_idx), .active_cnt(active_cnt)
  );

  typedef struct {
    logic [N-1:0] mv;
    logic         hit;
    int           idx;
    int           lat;
    int           nvalid;
    int           c0;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  logic [W-1:0] m_data [N];
  logic [W-1:0] m_care [N];
  logic         m_valid [N];
  logic [N-1:0] last_mv;
  int vectors = 0, fails = 0, cyc = 0;
  bit mon_prev_busy = 1'b0;
  int mon_prev_cnt = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  // reference: R3 ternary compare, R4 MSB-first order, R5 written rows only, R8 early end
  function automatic exp_t model(input logic [W-1:0] key, input string tag);
    exp_t e;
    e.mv = '0; e.hit = 1'b0; e.idx = 0; e.lat = 1; e.nvalid = 0; e.tag = tag; e.c0 = 0;
    for (int i = 0; i < N; i++) begin
      if (m_valid[i]) begin
        int stop_at;
        stop_at = W;
        e.nvalid++;
        for (int b = W-1; b >= 0; b--) begin
          if (m_care[i][b] && (m_data[i][b] != key[b])) begin
            stop_at = W - b;
            break;
          end
        end
        if (stop_at == W && !(m_care[i][0] && (m_data[i][0] != key[0]))) begin
          e.mv[i] = 1'b1;
        end
        if (stop_at > e.lat) e.lat = stop_at;
      end
    end
    if (e.mv != '0) e.lat = W;
    for (int i = N-1; i >= 0; i--) if (e.mv[i]) e.idx = i;
    e.hit = (e.mv != '0);
    return e;
  endfunction

  // all driver tasks start and end at a falling edge
  task automatic do_write(input int a, input logic [W-1:0] d, input logic [W-1:0] c);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_care = c;
    chk(wr_ready == 1'b1, "R2", $sformatf("wr_ready=%0b", wr_ready), "1");
    @(negedge clk);
    wr_en = 1'b0;
    m_data[a] = d; m_care[a] = c; m_valid[a] = 1'b1;
  endtask

  task automatic start_search(input logic [W-1:0] key, input string tag);
    exp_t e;
    e = model(key, tag);
    e.c0 = cyc;
    sb_q.push_back(e);
    srch_start = 1'b1; srch_key = key;
    @(negedge clk);
    srch_start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (busy && !mon_prev_busy && sb_q.size() > 0)
        chk(int'(active_cnt) == sb_q[0].nvalid, "R6 first-cycle count",
            $sformatf("%0d", active_cnt), $sformatf("%0d", sb_q[0].nvalid));
      if (busy && mon_prev_busy)
        chk(int'(active_cnt) <= mon_prev_cnt, "R6 count rise",
            $sformatf("%0d", active_cnt), $sformatf("<=%0d", mon_prev_cnt));
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R11 unexpected done", "done", "none");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(match_vec == e.mv, {"R3/R9 match_vec ", e.tag},
              $sformatf("%h", match_vec), $sformatf("%h", e.mv));
          chk(hit == e.hit && (!e.hit || int'(hit_idx) == e.idx), {"R9 hit/idx ", e.tag},
              $sformatf("%0b/%0d", hit, hit_idx), $sformatf("%0b/%0d", e.hit, e.idx));
          chk(cyc - e.c0 - 1 == e.lat, {"R7/R8 latency ", e.tag},
              $sformatf("%0d", cyc - e.c0 - 1), $sformatf("%0d", e.lat));
          chk(!busy, "R7 busy low at done", $sformatf("%0b", busy), "0");
          last_mv = e.mv;
        end
      end
      mon_prev_busy = busy;
      mon_prev_cnt  = int'(active_cnt);
    end
  end

  localparam logic [W-1:0] KA = 64'hDEAD_BEEF_0123_4567;
  localparam logic [W-1:0] KB = 64'h0123_4567_89AB_CDEF;

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_care = '0;
    srch_start = 1'b0; srch_key = '0; last_mv = '0;
    for (int i = 0; i < N; i++) begin m_valid[i] = 1'b0; m_data[i] = '0; m_care[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !hit && match_vec == '0 && active_cnt == '0, "R1 in reset",
        $sformatf("%0b%0b%0b cnt=%0d", busy, done, hit, active_cnt), "000 cnt=0");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && active_cnt == '0 && wr_ready, "R1 after release",
        $sformatf("busy=%0b cnt=%0d rdy=%0b", busy, active_cnt, wr_ready), "busy=0 cnt=0 rdy=1");

    // R5/R8: empty table ends after one cycle with no hit
    start_search(KA, "empty"); wait_done(); @(negedge clk);

    // R2 writes; R8 every row loses at the top bit
    do_write(5, KA, '1);
    do_write(9, KA ^ 64'h00FF, ~64'hFFFF);
    start_search(64'h0, "miss-at-msb"); wait_done(); @(negedge clk);

    // R8: last row drops a few bits down
    do_write(3, KB, '1);
    start_search(~KA, "miss-deep"); wait_done(); @(negedge clk);

    // R3/R9: exact plus don't-care row, lowest index wins
    start_search(KA, "two-hit"); wait_done();
    // R12: new search in the done cycle
    start_search(KA ^ 64'h1, "back-to-back dc row"); wait_done(); @(negedge clk);

    do_write(20, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    do_write(127, '0, '0);
    start_search(64'hF000_0000_0000_0001, "msb-only"); wait_done(); @(negedge clk);
    start_search(64'h0000_0000_0000_0001, "all-dc row"); wait_done();
    repeat (3) @(negedge clk);
    chk(match_vec == last_mv, "R9 result held", $sformatf("%h", match_vec), $sformatf("%h", last_mv));

    // R10: write held during a search is blocked and lost
    start_search(KB, "write-stall");
    for (int k = 0; k < 5; k++) begin
      wr_en = 1'b1; wr_addr = AW'(3); wr_data = ~KB; wr_care = '1;
      chk(wr_ready == 1'b0, "R10 wr_ready in scan", $sformatf("%0b", wr_ready), "0");
      @(negedge clk);
    end
    wr_en = 1'b0;
    wait_done(); @(negedge clk);
    start_search(KB, "R10 entry unchanged"); wait_done(); @(negedge clk);

    // R11: second start while busy ignored
    start_search(KA, "start-while-busy");
    @(negedge clk); @(negedge clk);
    srch_start = 1'b1; srch_key = KB;
    @(negedge clk);
    srch_start = 1'b0;
    wait_done(); @(negedge clk);
    chk(!busy && !done, "R11 no second search", $sformatf("busy=%0b done=%0b", busy, done), "0/0");

    // random keys near stored rows
    for (int r = 0; r < 20; r++) begin
      int a;
      logic [W-1:0] k;
      do_write(30 + r, {$urandom, $urandom}, {$urandom, $urandom} | 64'hFF00_0000_0000_0000);
      a = 30 + ($urandom % (r + 1));
      k = m_data[a] ^ (64'h1 << ($urandom % W));
      start_search(k, $sformatf("rand%0d", r)); wait_done(); @(negedge clk);
    end

    chk(sb_q.size() == 0, "R7 all searches ended", $sformatf("%0d", sb_q.size()), "0");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule